// File: doc/BRIEF.md
# Flash Command Source Arbiter

This block decides which of four requesters may start the next command sequence on a shared flash sequencer. The requesters are a memory-mapped bus read path, a bus write path, a command started by software through registers, and a previously suspended command that wants to resume. Exactly one requester holds the sequencer at a time. The grant stays in place until the sequencer reports that the sequence is done. The source of the current or most recent grant is reported as a 2-bit code.

Each waiting requester, other than the suspended one, is watched by a timer. The timer counts in blocks of 1024 clock cycles, and its limit is set at run time. If a request waits past its limit without a grant, it is dropped and the requester receives a one-cycle error pulse in place of a grant. A sticky grant-timeout flag is also raised: one flag serves both bus paths and a separate flag serves the register command. A suspended command may resume only after the whole interface has stayed idle for a set number of cycles. The interface counts as idle when the arbiter holds no grant and the sequencer reports idle. A third sticky flag marks the completion of a register-triggered sequence. Software clears any flag by writing a 1 to the matching clear bit.

Top module: `cmd_src_arbiter`

## Requirements
- R1: After reset, `gnt_vec`, `err_vec` and `flags` are 0 and `src_code` is 0. At most one bit of `gnt_vec` is set, and bit i belongs to source code i: 0 bus read, 1 bus write, 2 register command, 3 suspended command. `src_code` holds the code of the latest grant until the next grant.
- R2: At an edge where no grant is held, the eligible requester with the highest priority is granted. The order, highest first, is suspended, bus read, bus write, register command. `gnt_vec` shows the grant after that edge.
- R3: A grant is held until an edge with `seq_done` high. After that edge `gnt_vec` is 0 for at least one cycle. Requests that arrive while a grant is held do not change it.
- R4: `bus_idle` is high exactly when no grant is held and `seq_idle` is high.
- R5: A suspended request is eligible only when `bus_idle` is high at the edge and was also high at each of the `resume_wait_cfg` edges just before it. A value of 0 lets it go at once.
- R6: A register command that waits `ip_tmo_cfg`×1024 edges without a grant gets a one-cycle `err_vec[2]` pulse at the last of those edges, and `flags[1]` is set. A value of 0 turns the timeout off.
- R7: A bus read or bus write that waits `bus_tmo_cfg`×1024 edges without a grant gets a one-cycle pulse on `err_vec[0]` or `err_vec[1]`, and `flags[0]` is set. A value of 0 turns the timeout off.
- R8: The suspended request never times out, so `err_vec[3]` stays 0.
- R9: `flags[2]` is set at an edge where `seq_done` is high while the register command holds the grant. It is not set when other sources finish.
- R10: The flags are sticky. A 1 on `flag_clr[k]` clears `flags[k]` at the next edge. If a set and a clear fall on the same edge, the set wins.
- R11: A timed-out request is not granted again until its request line has gone low and then been raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Bus read wants a sequence |
| wr_req | input | 1 | Bus write wants a sequence |
| ip_req | input | 1 | Register-triggered command wants a sequence |
| sus_req | input | 1 | Suspended command wants to resume |
| seq_done | input | 1 | Sequencer finished the granted sequence |
| seq_idle | input | 1 | Sequencer is idle |
| bus_tmo_cfg | input | CFG_W | Bus grant timeout, in units of 1024 cycles (0 turns it off) |
| ip_tmo_cfg | input | CFG_W | Register-command grant timeout, in units of 1024 cycles (0 turns it off) |
| resume_wait_cfg | input | WAIT_W | Idle cycles required before a resume |
| flag_clr | input | 3 | Write-1-to-clear strobes for `flags` |
| gnt_vec | output | 4 | One-hot grant, indexed by source code |
| err_vec | output | 4 | One-cycle timeout error response, indexed by source code |
| src_code | output | 2 | Code of the latest granted source |
| bus_idle | output | 1 | No grant held and sequencer idle |
| flags | output | 3 | Sticky flags: [0] bus grant timeout, [1] register grant timeout, [2] register sequence done |

## Verification
The hardest case to reach from the ports is a timeout that expires exactly on its 1024-multiple edge while another source holds the sequencer. The stimulus gets there by parking a grant on one source without ever sending `seq_done`. It then raises the victim request on a known edge and counts edges. The bench checks that no error appears one edge before the limit and that the error does appear on the limit edge. After that, it releases the parked grant and shows that the dropped request stays ungranted until its line is lowered and raised again. The resume gate is reached the same way: the idle window is counted from the edge where `seq_done` releases a held grant.

// File: rtl/cmdarb_pkg.sv
package cmdarb_pkg;

  typedef enum logic [1:0] {
    SRC_RD  = 2'd0,
    SRC_WR  = 2'd1,
    SRC_IP  = 2'd2,
    SRC_SUS = 2'd3
  } src_e;

  localparam int NSRC  = 4;
  localparam int NTMO  = 3;   // sources with a grant timer: read, write, register
  localparam int NFLAG = 3;
  localparam int FLG_BUS_TMO = 0;
  localparam int FLG_IP_TMO  = 1;
  localparam int FLG_IP_DONE = 2;

  // Fixed priority: suspended, read, write, register command.
  function automatic logic [NSRC-1:0] pick_winner(input logic [NSRC-1:0] elig);
    if (elig[SRC_SUS])     return 4'b1000;
    else if (elig[SRC_RD]) return 4'b0001;
    else if (elig[SRC_WR]) return 4'b0010;
    else if (elig[SRC_IP]) return 4'b0100;
    else                   return 4'b0000;
  endfunction

  function automatic logic [1:0] code_of(input logic [NSRC-1:0] onehot);
    case (onehot)
      4'b0010: return SRC_WR;
      4'b0100: return SRC_IP;
      4'b1000: return SRC_SUS;
      default: return SRC_RD;
    endcase
  endfunction

endpackage

// File: rtl/cmdarb_wait_timer.sv
module cmdarb_wait_timer #(
  parameter int CFG_W     = 8,
  parameter int UNIT_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             won,
  input  logic [CFG_W-1:0] cfg,
  output logic             fire
);
  localparam int CNT_W = CFG_W + UNIT_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = {cfg, {UNIT_LOG2{1'b0}}};
  // Fires on the limit-th waiting edge unless a grant wins that same edge.
  assign fire  = live && !won && (cfg != '0) && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!live || won || fire) cnt <= '0;
    else                         cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/cmdarb_idle_gate.sv
module cmdarb_idle_gate #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_idle,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              resume_ok
);
  logic [WAIT_W-1:0] idle_cnt;

  assign resume_ok = bus_idle && (idle_cnt >= wait_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!bus_idle)         idle_cnt <= '0;
    else if (idle_cnt != '1)    idle_cnt <= idle_cnt + WAIT_W'(1);
  end
endmodule

// File: rtl/cmdarb_grant_ctrl.sv
module cmdarb_grant_ctrl
  import cmdarb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] elig,
  input  logic            seq_done,
  output logic [NSRC-1:0] win,
  output logic [NSRC-1:0] gnt_q,
  output logic [1:0]      code_q,
  output logic            busy
);
  assign busy = |gnt_q;
  assign win  = busy ? '0 : pick_winner(elig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      code_q <= SRC_RD;
    end else if (busy) begin
      if (seq_done) gnt_q <= '0;
    end else if (win != '0) begin
      gnt_q  <= win;
      code_q <= code_of(win);
    end
  end
endmodule

// File: rtl/cmd_src_arbiter.sv
module cmd_src_arbiter
  import cmdarb_pkg::*;
#(
  parameter int CFG_W     = 8,
  parameter int UNIT_LOG2 = 10,
  parameter int WAIT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              ip_req,
  input  logic              sus_req,
  input  logic              seq_done,
  input  logic              seq_idle,
  input  logic [CFG_W-1:0]  bus_tmo_cfg,
  input  logic [CFG_W-1:0]  ip_tmo_cfg,
  input  logic [WAIT_W-1:0] resume_wait_cfg,
  input  logic [2:0]        flag_clr,
  output logic [3:0]        gnt_vec,
  output logic [3:0]        err_vec,
  output logic [1:0]        src_code,
  output logic              bus_idle,
  output logic [2:0]        flags
);
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  win;
  logic [NTMO-1:0]  dropped;
  logic [NTMO-1:0]  live;
  logic [NTMO-1:0]  fire;
  logic [NSRC-1:0]  err_q;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_set;
  logic             busy;
  logic             resume_ok;

  assign req      = {sus_req, ip_req, wr_req, rd_req};
  assign bus_idle = !busy && seq_idle;

  cmdarb_idle_gate #(.WAIT_W(WAIT_W)) idle_gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_idle  (bus_idle),
    .wait_cfg  (resume_wait_cfg),
    .resume_ok (resume_ok)
  );

  for (genvar i = 0; i < NTMO; i++) begin : g_tmo
    assign live[i] = req[i] && !dropped[i] && !gnt_vec[i];
    assign elig[i] = req[i] && !dropped[i];

    cmdarb_wait_timer #(.CFG_W(CFG_W), .UNIT_LOG2(UNIT_LOG2)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (live[i]),
      .won   (win[i]),
      .cfg   ((i == int'(SRC_IP)) ? ip_tmo_cfg : bus_tmo_cfg),
      .fire  (fire[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dropped[i] <= 1'b0;
      else if (fire[i]) dropped[i] <= 1'b1;
      else if (!req[i]) dropped[i] <= 1'b0;
    end
  end
  assign elig[SRC_SUS] = sus_req && resume_ok;

  cmdarb_grant_ctrl grant_ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .seq_done (seq_done),
    .win      (win),
    .gnt_q    (gnt_vec),
    .code_q   (src_code),
    .busy     (busy)
  );

  assign flag_set[FLG_BUS_TMO] = fire[SRC_RD] || fire[SRC_WR];
  assign flag_set[FLG_IP_TMO]  = fire[SRC_IP];
  assign flag_set[FLG_IP_DONE] = seq_done && gnt_vec[SRC_IP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      flag_q <= '0;
    end else begin
      err_q  <= {1'b0, fire};
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  assign err_vec = err_q;
  assign flags   = flag_q;
endmodule

// File: rtl/cmd_src_arbiter_chk.sv
module cmd_src_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       seq_done,
  input logic       seq_idle,
  input logic [2:0] flag_clr,
  input logic [3:0] gnt_vec,
  input logic [3:0] err_vec,
  input logic [1:0] src_code,
  input logic       bus_idle,
  input logic [2:0] flags,
  input logic       resume_ok
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec)); // R1
  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec != 4'b0) |-> gnt_vec[src_code]); // R1
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec != 4'b0 && !seq_done) |=> (gnt_vec == $past(gnt_vec))); // R3
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec != 4'b0 && seq_done) |=> (gnt_vec == 4'b0)); // R3
  AST_IDLE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> (seq_idle && gnt_vec == 4'b0)); // R4
  AST_RESUME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_vec[3]) |-> $past(resume_ok)); // R5
  AST_ERR_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec & gnt_vec) == 4'b0); // R6
  AST_IP_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_vec[2] |=> !err_vec[2]); // R6
  AST_BUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec[0] || err_vec[1]) |-> flags[0]); // R7
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && gnt_vec[2]) |=> flags[2]); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !flag_clr[1]) |=> flags[1]); // R10
endmodule

bind cmd_src_arbiter cmd_src_arbiter_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .seq_done  (seq_done),
  .seq_idle  (seq_idle),
  .flag_clr  (flag_clr),
  .gnt_vec   (gnt_vec),
  .err_vec   (err_vec),
  .src_code  (src_code),
  .bus_idle  (bus_idle),
  .flags     (flags),
  .resume_ok (resume_ok)
);

// File: tb/cmd_src_arbiter_tb_top.sv
module cmd_src_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_req = 0, wr_req = 0, ip_req = 0, sus_req = 0;
  logic       seq_done = 0, seq_idle = 1;
  logic [7:0] bus_tmo_cfg = 0, ip_tmo_cfg = 0, resume_wait_cfg = 0;
  logic [2:0] flag_clr = 0;
  logic [3:0] gnt_vec, err_vec;
  logic [1:0] src_code;
  logic       bus_idle;
  logic [2:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmd_src_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .ip_req(ip_req),
    .sus_req(sus_req), .seq_done(seq_done), .seq_idle(seq_idle),
    .bus_tmo_cfg(bus_tmo_cfg), .ip_tmo_cfg(ip_tmo_cfg),
    .resume_wait_cfg(resume_wait_cfg), .flag_clr(flag_clr),
    .gnt_vec(gnt_vec), .err_vec(err_vec), .src_code(src_code),
    .bus_idle(bus_idle), .flags(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_done();
    seq_done = 1'b1;
    step();
    seq_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset gnt", gnt_vec, 4'b0);
    chk("R1 reset err", err_vec, 4'b0);
    chk("R1 reset code", src_code, 2'd0);
    chk("R1 reset flags", flags, 3'b0);
    chk("R4 idle after reset", bus_idle, 1'b1);
  endtask

  task automatic t_priority();
    resume_wait_cfg = 0;
    rd_req = 1; wr_req = 1; ip_req = 1; sus_req = 1;
    step();
    chk("R2 suspended first", gnt_vec, 4'b1000);
    chk("R1 code suspended", src_code, 2'd3);
    sus_req = 0;
    pulse_done();
    chk("R3 gap after done", gnt_vec, 4'b0);
    step();
    chk("R2 read second", gnt_vec, 4'b0001);
    chk("R1 code read", src_code, 2'd0);
    rd_req = 0;
    pulse_done();
    step();
    chk("R2 write third", gnt_vec, 4'b0010);
    chk("R1 code write", src_code, 2'd1);
    wr_req = 0;
    pulse_done();
    step();
    chk("R2 register last", gnt_vec, 4'b0100);
    chk("R1 code register", src_code, 2'd2);
    ip_req = 0;
    pulse_done();
    chk("R1 code held after release", src_code, 2'd2);
  endtask

  task automatic t_hold_idle();
    rd_req = 1; step(); rd_req = 0;
    chk("R4 not idle while granted", bus_idle, 1'b0);
    wr_req = 1; sus_req = 1;
    step(); step(); step();
    chk("R3 grant held against new requests", gnt_vec, 4'b0001);
    wr_req = 0; sus_req = 0;
    pulse_done();
    chk("R4 idle after release", bus_idle, 1'b1);
    seq_idle = 0;
    #1;
    chk("R4 sequencer busy clears idle", bus_idle, 1'b0);
    seq_idle = 1;
  endtask

  task automatic t_resume_gate();
    resume_wait_cfg = 5;
    rd_req = 1; step(); rd_req = 0;
    sus_req = 1;
    pulse_done();
    repeat (5) step();
    chk("R5 resume still gated", gnt_vec, 4'b0);
    step();
    chk("R5 resume after idle window", gnt_vec, 4'b1000);
    sus_req = 0;
    pulse_done();
    resume_wait_cfg = 0;
  endtask

  task automatic t_ip_timeout();
    ip_tmo_cfg = 1;
    rd_req = 1; step(); rd_req = 0;
    ip_req = 1;
    repeat (1023) step();
    chk("R6 no error before limit", err_vec, 4'b0);
    step();
    chk("R6 error on limit edge", err_vec, 4'b0100);
    chk("R6 register timeout flag", flags[1], 1'b1);
    step();
    chk("R6 error is one cycle", err_vec, 4'b0);
    pulse_done();
    step(); step();
    chk("R11 dropped request not granted", gnt_vec, 4'b0);
    ip_req = 0; step();
    ip_req = 1; step();
    chk("R11 re-raised request granted", gnt_vec, 4'b0100);
    ip_req = 0;
    pulse_done();
    ip_tmo_cfg = 0;
  endtask

  task automatic t_bus_timeout();
    bus_tmo_cfg = 2;
    ip_req = 1; step(); ip_req = 0;
    wr_req = 1;
    repeat (2047) step();
    chk("R7 no error before limit", err_vec, 4'b0);
    step();
    chk("R7 write error on limit edge", err_vec, 4'b0010);
    chk("R7 bus timeout flag", flags[0], 1'b1);
    wr_req = 0;
    pulse_done();
    bus_tmo_cfg = 0;
    flag_clr = 3'b010; step(); flag_clr = 3'b000;
    chk("R10 selective clear", flags[1:0], 2'b01);
  endtask

  task automatic t_no_timeout();
    bit seen_bus = 0;
    bit seen_sus = 0;
    bus_tmo_cfg = 0; ip_tmo_cfg = 1;
    ip_req = 1; step(); ip_req = 0;
    rd_req = 1; sus_req = 1;
    for (int k = 0; k < 3000; k++) begin
      step();
      if (err_vec[1:0] != 2'b0) seen_bus = 1;
      if (err_vec[3]) seen_sus = 1;
    end
    chk("R7 zero limit disables bus timeout", seen_bus, 1'b0);
    chk("R8 suspended never times out", seen_sus, 1'b0);
    pulse_done();
    step();
    chk("R2 waiting suspended beats read", gnt_vec, 4'b1000);
    sus_req = 0;
    pulse_done();
    step();
    chk("R2 read follows", gnt_vec, 4'b0001);
    rd_req = 0;
    pulse_done();
    ip_tmo_cfg = 0;
  endtask

  task automatic t_flags();
    flag_clr = 3'b111; step(); flag_clr = 3'b000;
    chk("R10 clear all", flags, 3'b000);
    rd_req = 1; step(); rd_req = 0;
    pulse_done();
    chk("R9 read finish leaves done flag", flags[2], 1'b0);
    ip_req = 1; step(); ip_req = 0;
    pulse_done();
    chk("R9 register finish sets done flag", flags[2], 1'b1);
    step();
    chk("R10 done flag sticky", flags[2], 1'b1);
    flag_clr = 3'b100; step(); flag_clr = 3'b000;
    chk("R10 done flag cleared", flags[2], 1'b0);
    ip_req = 1; step(); ip_req = 0;
    seq_done = 1; flag_clr = 3'b100;
    step();
    seq_done = 0; flag_clr = 3'b000;
    chk("R10 set wins over clear", flags[2], 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step(); step();
    t_reset();
    t_priority();
    t_hold_idle();
    t_resume_gate();
    t_ip_timeout();
    t_bus_timeout();
    t_no_timeout();
    t_flags();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule